// File: doc/BRIEF.md
# LED Matrix Row Scanner with Duty Control

This block drives a multiplexed 20-column by 8-row LED pixel array. It walks a refresh counter through a 512-tick frame and gives each row a 64-tick slot. Within each slot it turns on the columns whose pixel bit is set, for a number of ticks that a 4-bit duty code picks from a fixed non-linear table. The longest on-time is 60 ticks, so the last four ticks of every slot are always dark. Row 0 has no LEDs and is never lit.

Display ticks come from one of two strobe inputs, both sampled on the system clock. One is the internal oscillator strobe. The other is an external strobe, which can optionally be divided by 8. A sleep bit stops the ticks, darkens the array and holds the counter at the start of the frame, so the first frame after wake-up is complete. A blank input darkens the columns in the same cycle without disturbing the scan. The 2-bit peak-current code is passed through to the analog current reference.

Top module: `row_scan_pwm`

## Requirements
- R1: While awake, one frame is 512 display ticks. The active row is (tick count / 64) mod 8, and `row_o` is one-hot with bit r set for row r. The counter advances by one on each display tick and wraps after row 7, cycle 63.
- R2: A column is lit only while the tick position within the slot is below on-time[`ctl0_i[3:0]`]. The on-time table, indexed by codes 0 to 15, is 0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60. Slot positions 60 to 63 are therefore always dark.
- R3: `col_o[c]` shows `dots_i[8*c + r]` for the active row r. Row 0 is never lit, whatever its bits hold.
- R4: `blank_i` high forces `col_o` to zero in the same cycle. The scan counter keeps running underneath.
- R5: `ctl0_i[6]` low is sleep. In sleep `row_o` and `col_o` are zero, the counter is held at row 0, cycle 0, and the prescaler is cleared. After wake-up the scan starts at row 0, cycle 0.
- R6: `peak_o` always equals `ctl0_i[5:4]`.
- R7: With `osc_sel_i` high, each cycle with `int_tick_i` high is a display tick. With `osc_sel_i` low, only `ext_tick_i` counts, and `int_tick_i` is ignored.
- R8: With `osc_sel_i` low and `prescale_i` high, a 3-bit prescaler counts external strobes, and every eighth strobe is a display tick. The prescaler is cleared while `prescale_i` is low, while `osc_sel_i` is high, in sleep, and in reset. With `prescale_i` low, every external strobe is a display tick.
- R9: `rst_ni` low clears the counter to row 0, cycle 0 and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_sel_i | input | 1 | 1 selects the internal strobe, 0 selects the external strobe |
| int_tick_i | input | 1 | Internal oscillator strobe |
| ext_tick_i | input | 1 | External oscillator strobe |
| prescale_i | input | 1 | 1 divides the external strobe by 8 |
| ctl0_i | input | 7 | [3:0] duty code, [5:4] peak-current code, [6] 1 = run, 0 = sleep |
| blank_i | input | 1 | 1 darkens all columns immediately |
| dots_i | input | 160 | Pixel latch; bit 8*c + r is column c, row r |
| row_o | output | 8 | One-hot active-row select |
| col_o | output | 20 | Column drive for the active row |
| peak_o | output | 2 | Peak-current code for the analog reference |

## Verification
The hardest states to reach are the prescaler sitting part-way through its count of eight when sleep or a change of source clears it, and the tail of every slot at the largest duty code. Both depend on how many strobes have arrived, which the ports do not show directly. The stimulus therefore runs the external strobe at several spacings, with the divider on and off. It enters and leaves sleep partway through a frame. It sweeps all sixteen duty codes while the scan is at different slot positions, and a reference counter driven only from the input strobes is compared every cycle.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  localparam int unsigned ON_W = 6;

  // non-linear duty table: ticks lit per 64-tick slot
  function automatic logic [ON_W-1:0] on_time(input logic [3:0] code);
    logic [ON_W-1:0] t;
    case (code)
      4'd0:  t = 6'd0;
      4'd1:  t = 6'd1;
      4'd2:  t = 6'd2;
      4'd3:  t = 6'd3;
      4'd4:  t = 6'd4;
      4'd5:  t = 6'd5;
      4'd6:  t = 6'd7;
      4'd7:  t = 6'd9;
      4'd8:  t = 6'd11;
      4'd9:  t = 6'd14;
      4'd10: t = 6'd18;
      4'd11: t = 6'd22;
      4'd12: t = 6'd28;
      4'd13: t = 6'd36;
      4'd14: t = 6'd48;
      default: t = 6'd60;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/row_scan_tick_sel.sv
module row_scan_tick_sel #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  input  logic sel_i,
  input  logic int_tick_i,
  input  logic ext_tick_i,
  input  logic prescale_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] pre_q;
  logic          pre_clr;

  assign pre_clr = !awake_i || sel_i || !prescale_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (pre_clr)        pre_q <= '0;
    else if (ext_tick_i)     pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  always_comb begin
    if (!awake_i)   tick_o = 1'b0;
    else if (sel_i) tick_o = int_tick_i;
    else            tick_o = ext_tick_i && (!prescale_i || pre_q == LAST);
  end
endmodule

// File: rtl/row_scan_counter.sv
module row_scan_counter #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned SLOT = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    awake_i,
  input  logic                    tick_i,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic [$clog2(SLOT)-1:0] cyc_o
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned SW = $clog2(SLOT);

  logic [RW+SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!awake_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign row_o = cnt_q[RW+SW-1:SW];
  assign cyc_o = cnt_q[SW-1:0];
endmodule

// File: rtl/row_scan_col_gate.sv
module row_scan_col_gate #(
  parameter int unsigned COLS = 20,
  parameter int unsigned ROWS = 8,
  parameter int unsigned SLOT = 64
) (
  input  logic [COLS*ROWS-1:0]    dots_i,
  input  logic [$clog2(ROWS)-1:0] row_i,
  input  logic [$clog2(SLOT)-1:0] cyc_i,
  input  logic [$clog2(SLOT)-1:0] on_i,
  input  logic                    awake_i,
  input  logic                    blank_i,
  output logic [COLS-1:0]         col_o
);
  logic lit_en;

  assign lit_en = awake_i && !blank_i && (row_i != '0) && (cyc_i < on_i);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    assign col_bits = dots_i[c*ROWS +: ROWS];
    assign col_o[c] = lit_en && col_bits[row_i];
  end
endmodule

// File: rtl/row_scan_pwm.sv
module row_scan_pwm #(
  parameter int unsigned COLS = 20,
  parameter int unsigned ROWS = 8,
  parameter int unsigned SLOT = 64,
  parameter int unsigned DIV  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_sel_i,
  input  logic                 int_tick_i,
  input  logic                 ext_tick_i,
  input  logic                 prescale_i,
  input  logic [6:0]           ctl0_i,
  input  logic                 blank_i,
  input  logic [COLS*ROWS-1:0] dots_i,
  output logic [ROWS-1:0]      row_o,
  output logic [COLS-1:0]      col_o,
  output logic [1:0]           peak_o
);
  import row_scan_pkg::*;

  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned SW = $clog2(SLOT);

  logic          awake;
  logic          disp_tick;
  logic [RW-1:0] row_idx;
  logic [SW-1:0] cyc;
  logic [SW-1:0] on_cyc;

  assign awake  = ctl0_i[6];
  assign peak_o = ctl0_i[5:4];
  assign on_cyc = SW'(on_time(ctl0_i[3:0]));

  row_scan_tick_sel #(.DIV(DIV)) i_tick_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .awake_i    (awake),
    .sel_i      (osc_sel_i),
    .int_tick_i (int_tick_i),
    .ext_tick_i (ext_tick_i),
    .prescale_i (prescale_i),
    .tick_o     (disp_tick)
  );

  row_scan_counter #(.ROWS(ROWS), .SLOT(SLOT)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .awake_i (awake),
    .tick_i  (disp_tick),
    .row_o   (row_idx),
    .cyc_o   (cyc)
  );

  row_scan_col_gate #(.COLS(COLS), .ROWS(ROWS), .SLOT(SLOT)) i_col_gate (
    .dots_i  (dots_i),
    .row_i   (row_idx),
    .cyc_i   (cyc),
    .on_i    (on_cyc),
    .awake_i (awake),
    .blank_i (blank_i),
    .col_o   (col_o)
  );

  always_comb begin
    row_o = '0;
    if (awake) row_o[row_idx] = 1'b1;
  end
endmodule

// File: rtl/row_scan_pwm_chk.sv
module row_scan_pwm_chk #(
  parameter int unsigned COLS = 20,
  parameter int unsigned ROWS = 8,
  parameter int unsigned SLOT = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [6:0]              ctl0_i,
  input logic                    blank_i,
  input logic [ROWS-1:0]         row_o,
  input logic [COLS-1:0]         col_o,
  input logic [$clog2(SLOT)-1:0] cyc
);
  // R1
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl0_i[6] |-> $countones(row_o) == 1);

  // R5
  sleep_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl0_i[6] |-> (row_o == '0 && col_o == '0));

  // R5
  wake_row0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl0_i[6]) |-> row_o == ROWS'(1));

  // R4
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> col_o == '0);

  // R3
  row0_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o[0] |-> col_o == '0);

  // R2
  slot_tail_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 60) |-> col_o == '0);
endmodule

bind row_scan_pwm row_scan_pwm_chk #(.COLS(COLS), .ROWS(ROWS), .SLOT(SLOT)) i_row_scan_pwm_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctl0_i  (ctl0_i),
  .blank_i (blank_i),
  .row_o   (row_o),
  .col_o   (col_o),
  .cyc     (cyc)
);

// File: tb/test_row_scan_pwm.sv
module test_row_scan_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 20;
  localparam int ROWS = 8;

  typedef struct {
    logic [ROWS-1:0] row;
    logic [COLS-1:0] col;
    logic [1:0]      peak;
    string           req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_sel = 1'b1, int_tick = 1'b1, ext_tick = 1'b0, prescale = 1'b0;
  logic [6:0] ctl0 = 7'h0F;
  logic blank = 1'b0;
  logic [COLS*ROWS-1:0] dots = '0;
  logic [ROWS-1:0] row_w;
  logic [COLS-1:0] col_w;
  logic [1:0] peak_w;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb_q[$];
  logic [8:0] m_cnt;
  logic [2:0] m_pre;
  int tbl [16] = '{0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60};

  always #(CLK_PERIOD/2) clk = ~clk;

  row_scan_pwm i_row_scan_pwm (
    .clk_i(clk), .rst_ni(rst_n), .osc_sel_i(osc_sel), .int_tick_i(int_tick),
    .ext_tick_i(ext_tick), .prescale_i(prescale), .ctl0_i(ctl0), .blank_i(blank),
    .dots_i(dots), .row_o(row_w), .col_o(col_w), .peak_o(peak_w)
  );

  // reference scan position from the input strobes (R1, R7, R8, R9)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_pre <= '0;
    end else if (!ctl0[6]) begin
      m_cnt <= '0; m_pre <= '0;
    end else if (osc_sel) begin
      m_pre <= '0;
      if (int_tick) m_cnt <= m_cnt + 1'b1;
    end else if (!prescale) begin
      m_pre <= '0;
      if (ext_tick) m_cnt <= m_cnt + 1'b1;
    end else if (ext_tick) begin
      m_pre <= m_pre + 1'b1;
      if (m_pre == 3'd7) m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic run(input int n, input int ext_period, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int r, cy;
      @(negedge clk);
      r  = int'(m_cnt[8:6]);
      cy = int'(m_cnt[5:0]);
      e.row  = ctl0[6] ? ROWS'(1 << r) : '0;
      e.peak = ctl0[5:4];
      e.req  = req;
      for (int c = 0; c < COLS; c++)
        e.col[c] = ctl0[6] && !blank && r != 0 && cy < tbl[ctl0[3:0]] && dots[c*ROWS + r];
      sb_q.push_back(e);
      #2;
      ext_tick = (ext_period != 0) && (i % ext_period == 0);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (row_w !== e.row || col_w !== e.col || peak_w !== e.peak) begin
        errors++;
        $display("FAIL %s row=%h/%h col=%h/%h peak=%0d/%0d (actual/expected)",
                 e.req, row_w, e.row, col_w, e.col, peak_w, e.peak);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: in reset, asleep, then awake
    run(3, 0, "R9");
    ctl0 = 7'h4F;
    run(3, 0, "R9");
    rst_n = 1'b1;
    // R1: full frames, all pixels on, largest duty
    ctl0 = 7'h6F;
    dots = '1;
    run(1100, 0, "R1");
    // R2: every duty code at shifting slot positions
    for (int k = 0; k < 16; k++) begin
      ctl0 = {3'b110, 4'(k)};
      for (int w = 0; w < COLS*ROWS/32; w++) dots[w*32 +: 32] = $urandom;
      run(130, 0, "R2");
    end
    // R3: pixel mapping with sparse patterns incl. row 0 bits set
    ctl0 = 7'h6F;
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < COLS*ROWS/32; w++) dots[w*32 +: 32] = $urandom;
      for (int c = 0; c < COLS; c++) dots[c*ROWS] = 1'b1;
      run(520, 0, "R3");
    end
    // R4: blank toggling, scan continues
    dots = '1;
    for (int i = 0; i < 40; i++) begin
      blank = (i % 3 == 0);
      run(7, 0, "R4");
    end
    blank = 1'b0;
    // R6: peak code passthrough
    for (int p = 0; p < 4; p++) begin
      ctl0 = {1'b1, 2'(p), 4'hE};
      run(20, 0, "R6");
    end
    // R5: sleep mid-frame, then wake at row 0 cycle 0
    ctl0 = 7'h0F;
    run(50, 0, "R5");
    ctl0 = 7'h4F;
    run(200, 0, "R5");
    // R7: external strobe without divider; internal strobe ignored
    osc_sel = 1'b0;
    run(300, 2, "R7");
    int_tick = 1'b0;
    run(150, 1, "R7");
    // R8: divided external strobe, sleep clears partial count
    prescale = 1'b1;
    run(1200, 1, "R8");
    run(605, 3, "R8");
    ctl0 = 7'h0F;
    run(10, 1, "R8");
    ctl0 = 7'h4F;
    run(700, 1, "R8");
    prescale = 1'b0;
    run(100, 1, "R8");
    @(negedge clk);
    #3;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule